// File: doc/BRIEF.md
# Configuration Fuse and Lock Bit Access Controller

This block gives a small processor a controlled path to its non-volatile configuration: it can read back the fuse byte and the lock bits, and it can program the lock bits from software. Access is opened by writing a control register with two enable bits: a special-read enable and a store enable. Once both are set, a short cycle-counted window opens. A load-from-program-memory strobe inside that window returns configuration data selected by a 16-bit pointer. A store-to-program-memory strobe inside that window programs lock bits from the data source register.

Both enables drop by themselves when an operation completes or when the window runs out. Outside a window, load strobes return the ordinary flash read data. An EEPROM write in progress freezes the control register and blocks special reads and stores. The fuse byte and lock bits are held in registers with parameterised reset values. Only the access and timing rules are modelled; no real flash programming takes place.

Top module: `fuse_lock_ctrl`

## Requirements
- R1: After reset both enables read 0, the result output is 0x00 and the lock bits hold LOCK_INIT (default 2'b11, both unprogrammed).
- R2: With both enables set, a load strobe in any of the first three cycles after the control write, with pointer 0x0001, returns {6'b111111, LB2, LB1}: lock bit 2 at bit 1 and lock bit 1 at bit 0. A programmed bit reads 0 and an unprogrammed bit reads 1.
- R3: Under the same window rule, pointer 0x0000 returns the fuse byte FUSE_INIT (default 0xDF). Any other pointer returns the flash read data.
- R4: A load strobe outside the load window, or with the enables clear, returns the flash read data. The result is registered and appears one cycle after the strobe.
- R5: Both enables clear on the edge that accepts a load or a store. With no accepted operation, they clear on the fourth edge after the control write.
- R6: A store strobe in any of the first four cycles after the control write ANDs data bits 1..0 into the lock bits. A 0 programs that bit, and a 1 leaves it unchanged. Programmed lock bits never return to 1.
- R7: A store strobe after the fourth cycle, or with the enables clear, leaves the lock bits unchanged.
- R8: While the EEPROM-busy input is high, control writes are ignored, and load or store strobes neither return configuration data nor change the lock bits.
- R9: When a load and a store strobe arrive in the same cycle inside a window, the load is served and the lock bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_rd | input | 1 | Special-read enable value written |
| ctl_st | input | 1 | Store enable value written |
| ptr | input | 16 | Pointer register value |
| st_data | input | 2 | Bits 1..0 of the data source register |
| lpm_stb | input | 1 | Load-from-program-memory strobe |
| spm_stb | input | 1 | Store-to-program-memory strobe |
| ee_busy | input | 1 | EEPROM write in progress |
| flash_rdata | input | 8 | Ordinary flash read data |
| rd_en | output | 1 | Special-read enable state |
| st_en | output | 1 | Store enable state |
| result | output | 8 | Load result, registered |

## Verification
Loads are swept over every delay from zero to five idle cycles after arming, against pointers 0, 1 and 2. This separates the three-cycle load window from the four-cycle store window, and separates the lock, fuse and pass-through decodes. Stores are swept over the same delays and all four values of data bits 1..0, followed by a readback. This shows which bit each data position programs and where the store window ends. Separate sequences cover accumulated stores that show programming is one-way, the timeout edge probed on both sides, EEPROM-busy blocking, and a load and store arriving together.

// File: rtl/fuse_lock_ctrl.sv
module fuse_lock_ctrl #(
  parameter logic [7:0] FUSE_INIT = 8'hDF,
  parameter logic [1:0] LOCK_INIT = 2'b11,
  parameter int RD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic        ctl_rd,
  input  logic        ctl_st,
  input  logic [15:0] ptr,
  input  logic [1:0]  st_data,
  input  logic        lpm_stb,
  input  logic        spm_stb,
  input  logic        ee_busy,
  input  logic [7:0]  flash_rdata,
  output logic        rd_en,
  output logic        st_en,
  output logic [7:0]  result
);
  localparam int CW = $clog2(ST_WIN + 1);

  logic [CW-1:0] cnt;
  logic [1:0]    lock_q;
  logic [7:0]    special;
  logic          armed, ld_ok, st_ok, expire;

  assign armed  = rd_en & st_en;
  assign ld_ok  = armed & lpm_stb & ~ee_busy & (cnt < CW'(RD_WIN));
  assign st_ok  = armed & spm_stb & ~lpm_stb & ~ee_busy & (cnt < CW'(ST_WIN));
  assign expire = (rd_en | st_en) & (cnt == CW'(ST_WIN - 1));

  assign special = (ptr == 16'h0001) ? {6'h3F, lock_q} :
                   (ptr == 16'h0000) ? FUSE_INIT : flash_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en <= 1'b0;
      st_en <= 1'b0;
      cnt   <= '0;
    end else if (ctl_we && !ee_busy) begin
      rd_en <= ctl_rd;
      st_en <= ctl_st;
      cnt   <= '0;
    end else if (ld_ok || st_ok || expire) begin
      rd_en <= 1'b0;
      st_en <= 1'b0;
      cnt   <= '0;
    end else if (rd_en || st_en) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= LOCK_INIT;
    else if (st_ok) lock_q <= lock_q & st_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result <= 8'h00;
    else if (lpm_stb) result <= ld_ok ? special : flash_rdata;
  end

  p_lock_one_way_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & ~$past(lock_q)) == 2'b00));

  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || st_en) |-> (cnt < CW'(ST_WIN)));

  p_clear_after_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ctl_we && (lpm_stb || spm_stb) && !ee_busy && cnt < CW'(RD_WIN))
      |=> (!rd_en && !st_en));

  p_busy_holds_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_busy && !rd_en && !st_en) |=> (!rd_en && !st_en));

  p_busy_keeps_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ee_busy |=> $stable(lock_q));

  p_plain_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_stb && !armed) |=> (result == $past(flash_rdata)));

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_stb && spm_stb) |=> $stable(lock_q));
endmodule

// File: tb/fuse_lock_ctrl_tb.sv
module fuse_lock_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_rd = 0, ctl_st = 0, lpm_stb = 0, spm_stb = 0, ee_busy = 0;
  logic [15:0] ptr = 16'h0;
  logic [1:0]  st_data = 2'b11;
  logic [7:0]  flash_rdata = 8'h00;
  logic rd_en, st_en;
  logic [7:0] result;
  int nvec = 0, nerr = 0;
  bit done = 0;

  localparam logic [7:0] FUSE = 8'hDF;
  localparam logic [1:0] LOCK0 = 2'b11;

  fuse_lock_ctrl u_dut (.clk, .rst_n, .ctl_we, .ctl_rd, .ctl_st, .ptr, .st_data,
    .lpm_stb, .spm_stb, .ee_busy, .flash_rdata, .rd_en, .st_en, .result);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic arm();
    ctl_we = 1; ctl_rd = 1; ctl_st = 1;
    @(negedge clk);
    ctl_we = 0; ctl_rd = 0; ctl_st = 0;
  endtask

  task automatic load(input logic [15:0] p);
    lpm_stb = 1; ptr = p;
    @(negedge clk);
    lpm_stb = 0;
  endtask

  task automatic store(input logic [1:0] d);
    spm_stb = 1; st_data = d;
    @(negedge clk);
    spm_stb = 0;
  endtask

  task automatic read_lock(input string req, input logic [1:0] exp);
    flash_rdata = 8'h00;
    arm();
    load(16'h0001);
    chk(req, result, {6'h3F, exp});
  endtask

  initial begin
    do_reset();
    chk("R1 enables", {6'h0, rd_en, st_en}, 8'h00);
    chk("R1 result", result, 8'h00);
    read_lock("R1 lock init", LOCK0);

    for (int d = 0; d < 6; d++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] exp;
        do_reset();
        flash_rdata = 8'h40 + 8'(d * 8 + p);
        arm();
        repeat (d) @(negedge clk);
        load(16'(p == 2 ? 5 : p));
        if (d < 3 && p == 1)      exp = {6'h3F, LOCK0};
        else if (d < 3 && p == 0) exp = FUSE;
        else                      exp = flash_rdata;
        chk(d < 3 ? "R2/R3 window load" : "R4 late load", result, exp);
        chk("R5 clear after load", {6'h0, rd_en, st_en}, 8'h00);
      end
    end

    for (int d = 0; d < 6; d++) begin
      for (int v = 0; v < 4; v++) begin
        do_reset();
        arm();
        repeat (d) @(negedge clk);
        store(2'(v));
        chk("R5 clear after store", {6'h0, rd_en, st_en}, 8'h00);
        read_lock(d < 4 ? "R6 store" : "R7 late store", d < 4 ? (LOCK0 & 2'(v)) : LOCK0);
      end
    end

    do_reset();
    arm(); store(2'b10);
    arm(); store(2'b01);
    arm(); store(2'b11);
    read_lock("R6 one way", 2'b00);

    do_reset();
    arm();
    repeat (3) @(negedge clk);
    chk("R5 still open", {6'h0, rd_en, st_en}, 8'h03);
    @(negedge clk);
    chk("R5 timeout", {6'h0, rd_en, st_en}, 8'h00);
    store(2'b00);
    read_lock("R7 store after timeout", LOCK0);

    do_reset();
    ee_busy = 1;
    arm();
    chk("R8 ctl blocked", {6'h0, rd_en, st_en}, 8'h00);
    ee_busy = 0;
    arm();
    ee_busy = 1;
    flash_rdata = 8'h77;
    load(16'h0000);
    chk("R8 read blocked", result, 8'h77);
    store(2'b00);
    ee_busy = 0;
    read_lock("R8 store blocked", LOCK0);

    do_reset();
    arm();
    lpm_stb = 1; spm_stb = 1; ptr = 16'h0000; st_data = 2'b00;
    @(negedge clk);
    lpm_stb = 0; spm_stb = 0;
    chk("R9 load wins", result, FUSE);
    read_lock("R9 lock kept", LOCK0);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule